// File: doc/BRIEF.md
# Dual-Port Block RAM with Selectable Clocking

This block is a true dual-port synchronous memory built on one 4096-bit storage array. Two ports, A and B, can each read and write the array. Each port has its own word width, chosen by a parameter as 1, 2, 4 or 8 bits. The depth follows from the width, so a port is 4096x1, 2048x2, 1024x4 or 512x8. The two ports share a single bit-level address map. A 4-bit port and an 8-bit port therefore see the same bits in the same order.

Every port registers its address, write data, write enable and lane enables. A write stage follows one input-clock edge later. Each port also has a registered read output.

A parameter chooses the clocking scheme.
- **Single-clock-per-port scheme:** every register of a port runs on that port's own clock, clock enable and clear. The output-side clock, enable and clear pins are ignored.
- **Split scheme:** the input registers run on one clock, with one clock enable and one clear. The output register runs on a second clock, with its own enable and clear.

All registers clear asynchronously. A clear never changes the stored data.

Top module: `dpram_clkmodes`

## Requirements
- R1: The array holds TOTAL_BITS (4096) bits. On a port of width N bits, word W covers array bits W*N through W*N+N-1, and bit k of the word is array bit W*N+k. This holds for every combination of the two ports' widths.
- R2: Each port's write data is split into LANES equal lanes, and lane j covers word bits j*N/LANES upward. A write changes only the lanes whose bit in the lane-enable input is 1. The write takes effect on the input-clock edge after the one that registers the address, data and write enable.
- R3: In the single-clock-per-port scheme, an address registered on clock edge k appears as read data on the output after edge k+1. It does not appear after edge k.
- R4: When a port reads the address it is writing, the output returns the contents from before that write (read-before-write).
- R5: In the single-clock-per-port scheme, the output-side clock, enable and clear inputs have no effect on the port.
- R6: In the split scheme, the output register changes only on the output clock and only while the output enable is 1. The input clear does not change the output register.
- R7: While a port's input clock enable is 0, its input registers hold their values and no write is performed. While its output enable is 0, its output register holds.
- R8: A clear forces the registers it covers to 0 at once, without waiting for a clock edge. An input clear that arrives after a write is registered, but before the write stage, cancels that write. No clear changes the array contents.
- R9: Port A and port B run on independent clocks. Data that one port writes can be read through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A input clock (in the single-clock scheme, drives all of port A) |
| a_ce | input | 1 | Port A input clock enable |
| a_clr | input | 1 | Port A input asynchronous clear, active high |
| a_oclk | input | 1 | Port A output clock (split scheme only) |
| a_oce | input | 1 | Port A output enable (split scheme only) |
| a_oclr | input | 1 | Port A output asynchronous clear (split scheme only) |
| a_addr | input | log2(TOTAL_BITS/A_WIDTH) | Port A word address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_lane_en | input | A_LANES | Port A lane enables |
| a_q | output | A_WIDTH | Port A registered read data |
| b_clk | input | 1 | Port B input clock (in the single-clock scheme, drives all of port B) |
| b_ce | input | 1 | Port B input clock enable |
| b_clr | input | 1 | Port B input asynchronous clear, active high |
| b_oclk | input | 1 | Port B output clock (split scheme only) |
| b_oce | input | 1 | Port B output enable (split scheme only) |
| b_oclr | input | 1 | Port B output asynchronous clear (split scheme only) |
| b_addr | input | log2(TOTAL_BITS/B_WIDTH) | Port B word address |
| b_wdata | input | B_WIDTH | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_lane_en | input | B_LANES | Port B lane enables |
| b_q | output | B_WIDTH | Port B registered read data |

## Verification
The hardest case to reach is a write that has been registered but is cancelled before it commits. That requires an input clear that lands in the half cycle between the registering edge and the write-stage edge. The bench registers the write on one rising edge, then pulses the clear just after the following falling edge and releases it before the next rising edge. It then reads the address back to confirm the old data survived.

In the split scheme, the output clock has to be shown as the only path to the output. For this the bench holds the output clock still while the input clock commits and re-registers the address. It then hand-pulses the output clock, first with the output enable low and then with it high.

// File: rtl/dpram_clkmodes.sv
module dpram_clkmodes #(
  parameter int unsigned TOTAL_BITS = 4096,
  parameter int unsigned A_WIDTH    = 8,
  parameter int unsigned A_LANES    = 2,
  parameter int unsigned B_WIDTH    = 4,
  parameter int unsigned B_LANES    = 1,
  parameter bit          SPLIT_CLK  = 1'b0,
  localparam int unsigned A_AW = $clog2(TOTAL_BITS / A_WIDTH),
  localparam int unsigned B_AW = $clog2(TOTAL_BITS / B_WIDTH)
) (
  input  logic               a_clk,
  input  logic               a_ce,
  input  logic               a_clr,
  input  logic               a_oclk,
  input  logic               a_oce,
  input  logic               a_oclr,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [A_WIDTH-1:0] a_wdata,
  input  logic               a_we,
  input  logic [A_LANES-1:0] a_lane_en,
  output logic [A_WIDTH-1:0] a_q,
  input  logic               b_clk,
  input  logic               b_ce,
  input  logic               b_clr,
  input  logic               b_oclk,
  input  logic               b_oce,
  input  logic               b_oclr,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [B_WIDTH-1:0] b_wdata,
  input  logic               b_we,
  input  logic [B_LANES-1:0] b_lane_en,
  output logic [B_WIDTH-1:0] b_q
);
  localparam int unsigned IW   = $clog2(TOTAL_BITS);
  localparam int unsigned A_SH = $clog2(A_WIDTH);
  localparam int unsigned B_SH = $clog2(B_WIDTH);
  localparam int unsigned A_LW = A_WIDTH / A_LANES;
  localparam int unsigned B_LW = B_WIDTH / B_LANES;

  // Two single-writer banks; the stored bit is their XOR.
  logic [TOTAL_BITS-1:0] bank_a, bank_b;
  wire  [TOTAL_BITS-1:0] cells = bank_a ^ bank_b;

  // ---------------- port A ----------------
  logic [A_AW-1:0]    a_addr_r;
  logic [A_WIDTH-1:0] a_data_r;
  logic               a_we_r;
  logic [A_LANES-1:0] a_lane_r;
  logic [A_WIDTH-1:0] a_bitmask;
  logic [IW-1:0]      a_base;

  always_ff @(posedge a_clk or posedge a_clr)
    if (a_clr) begin
      a_addr_r <= '0; a_data_r <= '0; a_we_r <= 1'b0; a_lane_r <= '0;
    end else if (a_ce) begin
      a_addr_r <= a_addr; a_data_r <= a_wdata; a_we_r <= a_we; a_lane_r <= a_lane_en;
    end

  for (genvar k = 0; k < A_WIDTH; k++) begin : g_amask
    assign a_bitmask[k] = a_lane_r[k / A_LW];
  end

  assign a_base = IW'(a_addr_r) << A_SH;
  wire [TOTAL_BITS-1:0] a_wmask = TOTAL_BITS'(a_bitmask) << a_base;
  wire [TOTAL_BITS-1:0] a_wvec  = TOTAL_BITS'(a_data_r) << a_base;
  wire [A_WIDTH-1:0]    a_rd    = A_WIDTH'(cells >> a_base);

  always_ff @(posedge a_clk)
    if (a_ce && a_we_r)
      bank_a <= (bank_a & ~a_wmask) | ((a_wvec ^ bank_b) & a_wmask);

  wire a_oclk_s = SPLIT_CLK ? a_oclk : a_clk;
  wire a_oce_s  = SPLIT_CLK ? a_oce  : a_ce;
  wire a_oclr_s = SPLIT_CLK ? a_oclr : a_clr;

  always_ff @(posedge a_oclk_s or posedge a_oclr_s)
    if (a_oclr_s)     a_q <= '0;
    else if (a_oce_s) a_q <= a_rd;

  p_in_hold_a_r7: assert property (@(posedge a_clk) disable iff (a_clr)
    !a_ce |=> ($stable(a_addr_r) && $stable(a_data_r) && $stable(a_we_r)));
  p_mem_hold_a_r7: assert property (@(posedge a_clk) disable iff (a_clr)
    !a_ce |=> $stable(bank_a));
  p_out_hold_a_r7: assert property (@(posedge a_oclk_s) disable iff (a_oclr_s)
    !a_oce_s |=> $stable(a_q));
  p_out_clear_a_r8: assert property (@(posedge a_oclk_s) disable iff (!a_oclr_s)
    a_oclr_s |-> (a_q == '0));

  // ---------------- port B ----------------
  logic [B_AW-1:0]    b_addr_r;
  logic [B_WIDTH-1:0] b_data_r;
  logic               b_we_r;
  logic [B_LANES-1:0] b_lane_r;
  logic [B_WIDTH-1:0] b_bitmask;
  logic [IW-1:0]      b_base;

  always_ff @(posedge b_clk or posedge b_clr)
    if (b_clr) begin
      b_addr_r <= '0; b_data_r <= '0; b_we_r <= 1'b0; b_lane_r <= '0;
    end else if (b_ce) begin
      b_addr_r <= b_addr; b_data_r <= b_wdata; b_we_r <= b_we; b_lane_r <= b_lane_en;
    end

  for (genvar k = 0; k < B_WIDTH; k++) begin : g_bmask
    assign b_bitmask[k] = b_lane_r[k / B_LW];
  end

  assign b_base = IW'(b_addr_r) << B_SH;
  wire [TOTAL_BITS-1:0] b_wmask = TOTAL_BITS'(b_bitmask) << b_base;
  wire [TOTAL_BITS-1:0] b_wvec  = TOTAL_BITS'(b_data_r) << b_base;
  wire [B_WIDTH-1:0]    b_rd    = B_WIDTH'(cells >> b_base);

  always_ff @(posedge b_clk)
    if (b_ce && b_we_r)
      bank_b <= (bank_b & ~b_wmask) | ((b_wvec ^ bank_a) & b_wmask);

  wire b_oclk_s = SPLIT_CLK ? b_oclk : b_clk;
  wire b_oce_s  = SPLIT_CLK ? b_oce  : b_ce;
  wire b_oclr_s = SPLIT_CLK ? b_oclr : b_clr;

  always_ff @(posedge b_oclk_s or posedge b_oclr_s)
    if (b_oclr_s)     b_q <= '0;
    else if (b_oce_s) b_q <= b_rd;

  p_in_hold_b_r7: assert property (@(posedge b_clk) disable iff (b_clr)
    !b_ce |=> ($stable(b_addr_r) && $stable(b_data_r) && $stable(b_we_r)));
  p_mem_hold_b_r7: assert property (@(posedge b_clk) disable iff (b_clr)
    !b_ce |=> $stable(bank_b));
  p_out_hold_b_r7: assert property (@(posedge b_oclk_s) disable iff (b_oclr_s)
    !b_oce_s |=> $stable(b_q));
  p_out_clear_b_r8: assert property (@(posedge b_oclk_s) disable iff (!b_oclr_s)
    b_oclr_s |-> (b_q == '0));
endmodule

// File: tb/dpram_clkmodes_tb.sv
`timescale 1ns/1ps
module dpram_clkmodes_tb;
  logic clk_a = 1'b0, clk_b = 1'b0, clk_o = 1'b0;
  int tests = 0, fails = 0;

  always #2.5 clk_a = ~clk_a;
  initial begin #1; forever #2.5 clk_b = ~clk_b; end

  logic       ce_a = 1'b1, clr_a = 1'b1, we_a = 1'b0;
  logic [8:0] addr_a = '0;
  logic [7:0] wd_a = '0, q_a;
  logic [1:0] le_a = 2'b11;
  logic       ce_b = 1'b1, clr_b = 1'b1, we_b = 1'b0;
  logic [9:0] addr_b = '0;
  logic [3:0] wd_b = '0, q_b;
  logic [0:0] le_b = 1'b1;

  dpram_clkmodes #(.SPLIT_CLK(1'b0)) u_dut (
    .a_clk(clk_a), .a_ce(ce_a), .a_clr(clr_a), .a_oclk(clk_o), .a_oce(1'b0), .a_oclr(1'b1),
    .a_addr(addr_a), .a_wdata(wd_a), .a_we(we_a), .a_lane_en(le_a), .a_q(q_a),
    .b_clk(clk_b), .b_ce(ce_b), .b_clr(clr_b), .b_oclk(clk_o), .b_oce(1'b0), .b_oclr(1'b1),
    .b_addr(addr_b), .b_wdata(wd_b), .b_we(we_b), .b_lane_en(le_b), .b_q(q_b));

  logic       io_ce = 1'b1, io_clr = 1'b1, io_oce = 1'b1, io_oclr = 1'b1, io_we = 1'b0;
  logic [8:0] io_addr = '0;
  logic [7:0] io_wd = '0, io_q;
  logic [3:0] io_qb;

  dpram_clkmodes #(.SPLIT_CLK(1'b1)) u_dut_io (
    .a_clk(clk_a), .a_ce(io_ce), .a_clr(io_clr), .a_oclk(clk_o), .a_oce(io_oce), .a_oclr(io_oclr),
    .a_addr(io_addr), .a_wdata(io_wd), .a_we(io_we), .a_lane_en(2'b11), .a_q(io_q),
    .b_clk(clk_b), .b_ce(1'b0), .b_clr(1'b1), .b_oclk(clk_b), .b_oce(1'b0), .b_oclr(1'b1),
    .b_addr(10'd0), .b_wdata(4'd0), .b_we(1'b0), .b_lane_en(1'b1), .b_q(io_qb));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_wr(logic [8:0] ad, logic [7:0] d, logic [1:0] ln);
    @(negedge clk_a); addr_a = ad; wd_a = d; le_a = ln; we_a = 1'b1;
    @(negedge clk_a); we_a = 1'b0;
    @(negedge clk_a);
  endtask

  task automatic a_rd(logic [8:0] ad, output logic [7:0] r);
    @(negedge clk_a); addr_a = ad; we_a = 1'b0;
    @(negedge clk_a);
    @(negedge clk_a); r = q_a;
  endtask

  task automatic b_wr(logic [9:0] ad, logic [3:0] d);
    @(negedge clk_b); addr_b = ad; wd_b = d; le_b = 1'b1; we_b = 1'b1;
    @(negedge clk_b); we_b = 1'b0;
    @(negedge clk_b);
  endtask

  task automatic b_rd(logic [9:0] ad, output logic [3:0] r);
    @(negedge clk_b); addr_b = ad; we_b = 1'b0;
    @(negedge clk_b);
    @(negedge clk_b); r = q_b;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_a);
    chk("R8 reset a_q", q_a, 0);
    chk("R8 reset b_q", q_b, 0);
    chk("R8 reset io_q", io_q, 0);
    clr_a = 0; clr_b = 0; io_clr = 0; io_oclr = 0;
  endtask

  task automatic t_aspect;
    logic [7:0] ra; logic [3:0] rb;
    a_wr(9'd7, 8'hA5, 2'b11);
    b_rd(10'd14, rb); chk("R1/R9 B word14", rb, 4'h5);
    b_rd(10'd15, rb); chk("R1/R9 B word15", rb, 4'hA);
    a_wr(9'd10, 8'h00, 2'b11);
    b_wr(10'd20, 4'h3);
    b_wr(10'd21, 4'hC);
    a_rd(9'd10, ra); chk("R1/R9 A sees B writes", ra, 8'hC3);
    a_rd(9'd7, ra); chk("R5 output pins ignored", ra, 8'hA5);
  endtask

  task automatic t_lanes;
    logic [7:0] ra;
    a_wr(9'd5, 8'hFF, 2'b11);
    a_wr(9'd5, 8'h00, 2'b10);
    a_rd(9'd5, ra); chk("R2 upper lane only", ra, 8'h0F);
    a_wr(9'd5, 8'h33, 2'b01);
    a_rd(9'd5, ra); chk("R2 lower lane only", ra, 8'h03);
  endtask

  task automatic t_latency;
    logic [7:0] ra;
    a_wr(9'd30, 8'h11, 2'b11);
    a_wr(9'd31, 8'h22, 2'b11);
    a_rd(9'd31, ra);
    @(negedge clk_a); addr_a = 9'd30;
    @(negedge clk_a); chk("R3 not after first edge", q_a, 8'h22);
    @(negedge clk_a); chk("R3 after second edge", q_a, 8'h11);
  endtask

  task automatic t_rbw;
    logic [7:0] ra;
    a_wr(9'd40, 8'h5A, 2'b11);
    @(negedge clk_a); addr_a = 9'd40; wd_a = 8'hC3; le_a = 2'b11; we_a = 1'b1;
    @(negedge clk_a); we_a = 1'b0;
    @(negedge clk_a); chk("R4 old data", q_a, 8'h5A);
    @(negedge clk_a); chk("R4 new data next", q_a, 8'hC3);
  endtask

  task automatic t_ce;
    logic [7:0] ra;
    a_wr(9'd50, 8'h77, 2'b11);
    a_wr(9'd51, 8'h10, 2'b11);
    a_rd(9'd50, ra);
    @(negedge clk_a); ce_a = 1'b0; addr_a = 9'd51; wd_a = 8'h99; we_a = 1'b1;
    repeat (3) @(negedge clk_a);
    chk("R7 output held", q_a, 8'h77);
    we_a = 1'b0; ce_a = 1'b1;
    a_rd(9'd51, ra); chk("R7 no write while disabled", ra, 8'h10);
  endtask

  task automatic t_clear;
    logic [7:0] ra;
    a_wr(9'd60, 8'h3E, 2'b11);
    a_rd(9'd60, ra);
    @(posedge clk_a); #1 clr_a = 1'b1;
    #0.5 chk("R8 async clear output", q_a, 8'h00);
    #0.5 clr_a = 1'b0;
    a_rd(9'd60, ra); chk("R8 contents kept", ra, 8'h3E);
    @(negedge clk_a); addr_a = 9'd60; wd_a = 8'h01; we_a = 1'b1;
    @(negedge clk_a); we_a = 1'b0;
    #0.5 clr_a = 1'b1; #0.5 clr_a = 1'b0;
    a_rd(9'd60, ra); chk("R8 pending write cancelled", ra, 8'h3E);
  endtask

  task automatic pulse_o;
    #0.5 clk_o = 1'b1; #0.5 clk_o = 1'b0;
  endtask

  task automatic t_split;
    @(negedge clk_a); io_addr = 9'd3; io_wd = 8'h3C; io_we = 1'b1;
    @(negedge clk_a); io_we = 1'b0;
    repeat (3) @(negedge clk_a);
    chk("R6 no output clock no change", io_q, 8'h00);
    io_oce = 1'b0; pulse_o;
    chk("R6 output enable low holds", io_q, 8'h00);
    io_oce = 1'b1; pulse_o;
    chk("R6 output clock loads", io_q, 8'h3C);
    @(negedge clk_a); io_clr = 1'b1; #0.5 io_clr = 1'b0;
    #0.5 chk("R6 input clear leaves output", io_q, 8'h3C);
    io_oclr = 1'b1; #0.5 chk("R8 output clear", io_q, 8'h00);
    io_oclr = 1'b0;
  endtask

  initial begin
    t_reset;
    t_aspect;
    t_lanes;
    t_latency;
    t_rbw;
    t_ce;
    t_clear;
    t_split;
    repeat (2) @(negedge clk_a);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule